// File: doc/BRIEF.md
# Key-Protected Pin Configuration Lock

This block guards the configuration of one 16-pin general-purpose I/O port. It sits on a single-cycle word-wide register bus and holds one lock bit per pin. The lock word changes only when the upper half of the written data carries a fixed 16-bit key. Once a keyed write has been accepted, the lock word is frozen until the next reset.

The per-pin lock vector leaves the block so that the port's other configuration registers can refuse writes to locked pins. A one-bit-per-pin stub configuration register is included and obeys that vector, which makes the lock's effect visible on the bus. When the lock word is read, the key half does not return the key. It returns a single lock-status bit.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, the lock word reads 0x0000_0000, `pin_lock` is all zero, `pin_cfg` is all zero and the stub configuration word reads 0.
- R2: A write at offset 0x018 whose data bits [31:16] equal 0x5FA0, made while the port is unlocked, loads data bits [15:0] into the lock mask and sets the locked flag at the next rising clock edge.
- R3: A write at offset 0x018 whose bits [31:16] differ from 0x5FA0 is discarded whole: the mask and the locked flag keep their values.
- R4: Once the locked flag is set, every write at offset 0x018 is ignored, including one with the correct key and one with a zero mask, until reset.
- R5: A read at offset 0x018 returns the mask in bits [15:0], the locked flag in bit 16 and zero in bits [31:17]. It never returns the key.
- R6: A write at offset 0x000 updates bit n of the stub configuration register from data bit n only where lock bit n is clear. Bits of locked pins keep their old value.
- R7: A read at offset 0x000 returns the stub configuration in bits [15:0] and zero above. Any other offset reads 0, and a write to any other offset changes no state.
- R8: `pin_lock` always equals the stored lock mask, and `pin_cfg` always equals the stub configuration register.
- R9: With `bus_we` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe; the write commits at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_lock | output | 16 | Per-pin lock vector for the port's configuration registers |
| pin_cfg | output | 16 | Stub configuration bits, one per pin |

## Verification
Read data is combinational from the stored state, so a read result is due in the same cycle as the address and is sampled 1 ns after the address settles, with no clock edge in between. A write is presented after a falling edge and commits at the next rising edge; `pin_lock`, `pin_cfg` and the read-back words are therefore due one edge after the strobe, and the bench samples them 1 ns after that edge. Writes that must have no effect are checked the same way, by reading the lock word and the outputs one edge after the discarded write.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
    localparam int unsigned PIN_CNT  = 16;
    localparam int unsigned KEY_W    = 16;
    localparam int unsigned WORD_W   = PIN_CNT + KEY_W;
    localparam int unsigned ADDR_W   = 8;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'h5FA0;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'h18;
endpackage

// File: rtl/gpio_lock_word.sv
module gpio_lock_word #(
    parameter int unsigned PINS = gpio_lock_pkg::PIN_CNT,
    parameter int unsigned KW   = gpio_lock_pkg::KEY_W,
    parameter logic [KW-1:0] KEY = gpio_lock_pkg::UNLOCK_KEY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [PINS+KW-1:0] wdata,
    output logic [PINS-1:0]    mask,
    output logic               locked
);
    localparam int unsigned DW = PINS + KW;

    typedef struct packed {
        logic [PINS-1:0] mask;
        logic            locked;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     key_ok;

    always_comb begin
        key_ok = (wdata[DW-1:PINS] == KEY);
        st_d   = st_q;
        if (wr_hit && key_ok && !st_q.locked) begin
            st_d.mask   = wdata[PINS-1:0];
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask   = st_q.mask;
    assign locked = st_q.locked;

    // R2: keyed write while unlocked loads the mask and sets the flag
    p_key_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[DW-1:PINS] == KEY && !locked)
        |=> (locked && mask == $past(wdata[PINS-1:0])));

    // R3: wrong key discards the whole write
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[DW-1:PINS] != KEY) |=> ($stable(mask) && $stable(locked)));

    // R4: frozen once locked
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(mask)));

    // R9: no write strobe, no change
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(mask) && $stable(locked)));
endmodule

// File: rtl/gpio_cfg_stub.sv
module gpio_cfg_stub #(
    parameter int unsigned PINS = gpio_lock_pkg::PIN_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [PINS-1:0] wbits,
    input  logic [PINS-1:0] lock,
    output logic [PINS-1:0] cfg
);
    typedef struct packed {
        logic [PINS-1:0] cfg;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PINS; i++) begin
            if (wr_hit && !lock[i]) st_d.cfg[i] = wbits[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    // R6: locked pins never change
    p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((cfg ^ $past(cfg)) & $past(lock)) == '0));

    // R6: unlocked pins take the written value
    p_unlocked_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((cfg & ~$past(lock)) == ($past(wbits) & ~$past(lock))));
endmodule

// File: rtl/gpio_lock_rdmux.sv
module gpio_lock_rdmux #(
    parameter int unsigned PINS = gpio_lock_pkg::PIN_CNT,
    parameter int unsigned KW   = gpio_lock_pkg::KEY_W,
    parameter int unsigned AW   = gpio_lock_pkg::ADDR_W,
    parameter logic [AW-1:0] LOCK_OFS = gpio_lock_pkg::OFS_LOCK,
    parameter logic [AW-1:0] CFG_OFS  = gpio_lock_pkg::OFS_CFG
) (
    input  logic [AW-1:0]      addr,
    input  logic [PINS-1:0]    mask,
    input  logic               locked,
    input  logic [PINS-1:0]    cfg,
    output logic [PINS+KW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == LOCK_OFS) begin
            rdata[PINS-1:0] = mask;
            rdata[PINS]     = locked;
        end else if (addr == CFG_OFS) begin
            rdata[PINS-1:0] = cfg;
        end
    end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
    import gpio_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [PIN_CNT-1:0] pin_lock,
    output logic [PIN_CNT-1:0] pin_cfg
);
    logic lock_hit, cfg_hit, locked;

    assign lock_hit = bus_we && (bus_addr == OFS_LOCK);
    assign cfg_hit  = bus_we && (bus_addr == OFS_CFG);

    gpio_lock_word u_lock (
        .clk(clk), .rst_n(rst_n), .wr_hit(lock_hit), .wdata(bus_wdata),
        .mask(pin_lock), .locked(locked)
    );

    gpio_cfg_stub u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_hit(cfg_hit), .wbits(bus_wdata[PIN_CNT-1:0]),
        .lock(pin_lock), .cfg(pin_cfg)
    );

    gpio_lock_rdmux u_rd (
        .addr(bus_addr), .mask(pin_lock), .locked(locked), .cfg(pin_cfg),
        .rdata(bus_rdata)
    );

    // R5: status bit set means bits above it stay zero at the lock offset
    p_rd_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_LOCK) |-> (bus_rdata[WORD_W-1:PIN_CNT+1] == '0));

    // R7: unmapped offsets read zero
    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_LOCK && bus_addr != OFS_CFG) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_lock_port_tb_top.sv
`timescale 1ns/1ps
module gpio_lock_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_lock, pin_cfg;

    int checks = 0;
    int failures = 0;
    logic [15:0] cfg_model = '0;

    always #4 clk = ~clk;

    gpio_lock_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_lock(pin_lock), .pin_cfg(pin_cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic we = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_model = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(8'h18, v); chk("R1 lock word", v, 32'h0);
        rd(8'h00, v); chk("R1 cfg word", v, 32'h0);
        chk("R1 pin_lock", {16'h0, pin_lock}, 32'h0);
        chk("R1 pin_cfg", {16'h0, pin_cfg}, 32'h0);
    endtask

    task automatic t_cfg_unlocked();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_A5A5);
        cfg_model = 16'hA5A5;
        chk("R6 unlocked cfg write", {16'h0, pin_cfg}, {16'h0, cfg_model});
        rd(8'h00, v); chk("R7 cfg readback", v, {16'h0, cfg_model});
    endtask

    task automatic t_wrong_key();
        logic [31:0] v;
        wr(8'h18, 32'h1234_00FF);
        rd(8'h18, v); chk("R3 wrong key", v, 32'h0);
        wr(8'h18, 32'h5FA1_00FF);
        rd(8'h18, v); chk("R3 near key", v, 32'h0);
        chk("R3 pin_lock", {16'h0, pin_lock}, 32'h0);
    endtask

    task automatic t_no_strobe();
        logic [31:0] v;
        wr(8'h18, 32'h5FA0_FFFF, 1'b0);
        rd(8'h18, v); chk("R9 lock without strobe", v, 32'h0);
        wr(8'h00, 32'h0000_0000, 1'b0);
        chk("R9 cfg without strobe", {16'h0, pin_cfg}, {16'h0, cfg_model});
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h04, 32'h5FA0_FFFF);
        rd(8'h04, v); chk("R7 unmapped read", v, 32'h0);
        rd(8'h18, v); chk("R7 unmapped write no lock", v, 32'h0);
        chk("R7 unmapped write no cfg", {16'h0, pin_cfg}, {16'h0, cfg_model});
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(8'h18, 32'h5FA0_00F0);
        rd(8'h18, v); chk("R2 R5 lock readback", v, 32'h0001_00F0);
        chk("R8 pin_lock", {16'h0, pin_lock}, 32'h0000_00F0);
    endtask

    task automatic t_frozen();
        logic [31:0] v;
        wr(8'h18, 32'h5FA0_FFFF);
        rd(8'h18, v); chk("R4 keyed rewrite", v, 32'h0001_00F0);
        wr(8'h18, 32'h0000_0000);
        rd(8'h18, v); chk("R4 clear attempt", v, 32'h0001_00F0);
    endtask

    task automatic t_cfg_locked();
        logic [31:0] v;
        logic [15:0] nv = 16'h5A5A;
        wr(8'h00, {16'h0, nv});
        cfg_model = (cfg_model & pin_lock) | (nv & ~16'h00F0);
        cfg_model = (16'hA5A5 & 16'h00F0) | (nv & ~16'h00F0);
        chk("R6 locked pins held", {16'h0, pin_cfg}, {16'h0, cfg_model});
        rd(8'h00, v); chk("R7 cfg readback locked", v, {16'h0, cfg_model});
    endtask

    task automatic t_zero_mask_lock();
        logic [31:0] v;
        do_reset();
        t_reset_state();
        wr(8'h18, 32'h5FA0_0000);
        rd(8'h18, v); chk("R2 R5 zero-mask lock", v, 32'h0001_0000);
        wr(8'h18, 32'h5FA0_FFFF);
        rd(8'h18, v); chk("R4 zero-mask frozen", v, 32'h0001_0000);
        wr(8'h00, 32'h0000_3C3C);
        chk("R6 all pins open", {16'h0, pin_cfg}, 32'h0000_3C3C);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_cfg_unlocked();
        t_wrong_key();
        t_no_strobe();
        t_unmapped();
        t_lock();
        t_frozen();
        t_cfg_locked();
        t_zero_mask_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule